// File: doc/BRIEF.md
# Transmit DMA Channel Control Sequencer

This block sequences one descriptor-driven transmit DMA channel. A level-sensitive run-enable bit starts and stops the channel. A poll strobe asks the channel to look again after it ran out of descriptors. Three simplified request/acknowledge handshakes stand in for the bus engines. The first fetches a descriptor and reports whether the DMA owns it. The second reads frame data from host memory. The third writes the completion status back into the descriptor. A status-valid input from the transmitter tells the sequencer that the frame has left.

The sequencer publishes its process state as a fixed 3-bit code that software can read. It launches each phase with a one-cycle request strobe. It also raises one-cycle event pulses when the channel stops, when it runs out of descriptors, and when a frame is complete. All outputs are registered, and a synchronous active-high reset clears everything.

Top module: `txdma_ctrl`

## Requirements
- R1: In the cycle after any clock edge with `rst` high, `state_code` is 000 and all request and event outputs are low, whatever the other inputs are.
- R2: `state_code` only ever takes these values: 000 stopped, 001 fetching a descriptor, 011 reading frame data, 010 waiting for transmit status, 111 closing the descriptor, 110 suspended.
- R3: From stopped, an edge with `run_en` high moves to 001 and raises `desc_req` for exactly one cycle.
- R4: A frame runs in this order. In 001, `desc_ack` with `desc_owned`=1 (and `run_en` high) moves to 011 with a one-cycle `rd_req`. `rd_ack` then moves to 010. `tx_stat_vld` then moves to 111 with a one-cycle `wb_req`. `wb_ack` then gives a one-cycle `evt_done`, and with `run_en` high the machine returns to 001 with `desc_req`.
- R5: In 001, `desc_ack` with `desc_owned`=0 and `run_en` high moves to 110 and pulses `evt_nobuf` once. The pulse does not repeat while the machine stays in 110.
- R6: In 110 with `run_en` high, `poll_wr` moves to 001 with a one-cycle `desc_req`. In every other state, `poll_wr` changes neither state nor outputs.
- R7: Clearing `run_en` while in 011, 010 or 111 does not cut the frame short. The frame completes through write-back. On `wb_ack` the machine goes to 000 with `evt_stopped` and `evt_done` high in the same cycle.
- R8: With `run_en` low, 110 goes to 000 on the next edge with `evt_stopped`. In 001, the stop is taken when `desc_ack` arrives: the machine goes to 000 with `evt_stopped`, with no `rd_req` and no `evt_nobuf`, whatever `desc_owned` says.
- R9: At most one of `desc_req`, `rd_req` and `wb_req` is high in any cycle. An acknowledge or status input that arrives outside the state waiting for it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Start/stop control level |
| poll_wr | input | 1 | Poll-demand write strobe |
| desc_ack | input | 1 | Descriptor fetch finished |
| desc_owned | input | 1 | Fetched descriptor is owned by the DMA (valid with desc_ack) |
| rd_ack | input | 1 | Frame data read finished |
| tx_stat_vld | input | 1 | Transmit status available |
| wb_ack | input | 1 | Descriptor status write-back finished |
| desc_req | output | 1 | Launch descriptor fetch (one cycle) |
| rd_req | output | 1 | Launch frame data read (one cycle) |
| wb_req | output | 1 | Launch status write-back (one cycle) |
| state_code | output | 3 | Process state code |
| evt_stopped | output | 1 | Channel entered stopped |
| evt_nobuf | output | 1 | Descriptor unavailable, entered suspended |
| evt_done | output | 1 | Frame completed and descriptor closed |

## Verification
The hardest situations to reach are the stop requests that land between frame boundaries. One is a stop that arrives while a descriptor fetch is still outstanding. The other is a stop that arrives part-way through the read, wait and close phases of a frame. In both, the exit must be delayed without being lost. The stimulus reaches them by dropping `run_en` in the cycle a handshake completes, and again while an owned descriptor's frame is in flight. It also issues a poll while suspended and in unrelated states, and sends stray acknowledges to phases not awaiting them. The expected code, strobes and pulses are queued cycle by cycle.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  localparam int STATE_W = 3;

  // Process state codes visible to software
  typedef enum logic [STATE_W-1:0] {
    TXS_STOP  = 3'b000,
    TXS_FETCH = 3'b001,
    TXS_WAIT  = 3'b010,
    TXS_READ  = 3'b011,
    TXS_SUSP  = 3'b110,
    TXS_CLOSE = 3'b111
  } txs_e;

  // Transition marks produced by the next-state logic
  localparam int EV_FETCH = 0;
  localparam int EV_READ  = 1;
  localparam int EV_CLOSE = 2;
  localparam int EV_STOP  = 3;
  localparam int EV_SUSP  = 4;
  localparam int EV_DONE  = 5;
  localparam int EV_N     = 6;

endpackage

// File: rtl/txdma_next.sv
module txdma_next
  import txdma_pkg::*;
(
  input  txs_e             cur,
  input  logic             run_en,
  input  logic             poll_wr,
  input  logic             desc_ack,
  input  logic             desc_owned,
  input  logic             rd_ack,
  input  logic             tx_stat_vld,
  input  logic             wb_ack,
  output txs_e             nxt,
  output logic [EV_N-1:0]  ev
);

  always_comb begin
    nxt = cur;
    ev  = '0;
    unique case (cur)
      TXS_STOP: begin
        if (run_en) begin
          nxt          = TXS_FETCH;
          ev[EV_FETCH] = 1'b1;
        end
      end
      TXS_FETCH: begin
        if (desc_ack) begin
          if (!run_en) begin
            nxt         = TXS_STOP;
            ev[EV_STOP] = 1'b1;
          end else if (desc_owned) begin
            nxt         = TXS_READ;
            ev[EV_READ] = 1'b1;
          end else begin
            nxt         = TXS_SUSP;
            ev[EV_SUSP] = 1'b1;
          end
        end
      end
      TXS_READ: begin
        if (rd_ack) nxt = TXS_WAIT;
      end
      TXS_WAIT: begin
        if (tx_stat_vld) begin
          nxt          = TXS_CLOSE;
          ev[EV_CLOSE] = 1'b1;
        end
      end
      TXS_CLOSE: begin
        if (wb_ack) begin
          ev[EV_DONE] = 1'b1;
          if (run_en) begin
            nxt          = TXS_FETCH;
            ev[EV_FETCH] = 1'b1;
          end else begin
            nxt         = TXS_STOP;
            ev[EV_STOP] = 1'b1;
          end
        end
      end
      TXS_SUSP: begin
        if (!run_en) begin
          nxt         = TXS_STOP;
          ev[EV_STOP] = 1'b1;
        end else if (poll_wr) begin
          nxt          = TXS_FETCH;
          ev[EV_FETCH] = 1'b1;
        end
      end
      default: nxt = TXS_STOP;
    endcase
  end

endmodule

// File: rtl/txdma_pulse.sv
module txdma_pulse #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] mark,
  output logic [N-1:0] pulse
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= mark[i];
    end
  end

endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               poll_wr,
  input  logic               desc_ack,
  input  logic               desc_owned,
  input  logic               rd_ack,
  input  logic               tx_stat_vld,
  input  logic               wb_ack,
  output logic               desc_req,
  output logic               rd_req,
  output logic               wb_req,
  output logic [STATE_W-1:0] state_code,
  output logic               evt_stopped,
  output logic               evt_nobuf,
  output logic               evt_done
);

  txs_e            state_q;
  txs_e            state_d;
  logic [EV_N-1:0] marks;
  logic [EV_N-1:0] pulses;

  txdma_next u_next (
    .cur        (state_q),
    .run_en     (run_en),
    .poll_wr    (poll_wr),
    .desc_ack   (desc_ack),
    .desc_owned (desc_owned),
    .rd_ack     (rd_ack),
    .tx_stat_vld(tx_stat_vld),
    .wb_ack     (wb_ack),
    .nxt        (state_d),
    .ev         (marks)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= TXS_STOP;
    else     state_q <= state_d;
  end

  txdma_pulse #(.N(EV_N)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .mark (marks),
    .pulse(pulses)
  );

  assign state_code  = state_q;
  assign desc_req    = pulses[EV_FETCH];
  assign rd_req      = pulses[EV_READ];
  assign wb_req      = pulses[EV_CLOSE];
  assign evt_stopped = pulses[EV_STOP];
  assign evt_nobuf   = pulses[EV_SUSP];
  assign evt_done    = pulses[EV_DONE];

endmodule

// File: rtl/txdma_ctrl_chk.sv
module txdma_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       run_en,
  input logic       poll_wr,
  input logic       desc_ack,
  input logic       desc_owned,
  input logic       rd_ack,
  input logic       tx_stat_vld,
  input logic       wb_ack,
  input logic       desc_req,
  input logic       rd_req,
  input logic       wb_req,
  input logic [2:0] state_code,
  input logic       evt_stopped,
  input logic       evt_nobuf,
  input logic       evt_done
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (state_code == 3'b000 && !desc_req && !rd_req && !wb_req
             && !evt_stopped && !evt_nobuf && !evt_done));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (state_code inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111}));

  assert_start_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b000 && run_en) |=> (state_code == 3'b001 && desc_req));

  assert_nobuf_enters_susp_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b001 && desc_ack && !desc_owned && run_en)
      |=> (state_code == 3'b110 && evt_nobuf));

  assert_nobuf_once_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b110 && $past(state_code) == 3'b110) |-> !evt_nobuf);

  assert_poll_resumes_R6: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b110 && run_en && poll_wr) |=> (state_code == 3'b001 && desc_req));

  assert_read_not_cut_R7: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b011 && rd_ack) |=> (state_code == 3'b010));

  assert_stop_event_state_R8: assert property (@(posedge clk) disable iff (rst)
    evt_stopped |-> (state_code == 3'b000));

  assert_one_request_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({desc_req, rd_req, wb_req}));

endmodule

bind txdma_ctrl txdma_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .poll_wr    (poll_wr),
  .desc_ack   (desc_ack),
  .desc_owned (desc_owned),
  .rd_ack     (rd_ack),
  .tx_stat_vld(tx_stat_vld),
  .wb_ack     (wb_ack),
  .desc_req   (desc_req),
  .rd_req     (rd_req),
  .wb_req     (wb_req),
  .state_code (state_code),
  .evt_stopped(evt_stopped),
  .evt_nobuf  (evt_nobuf),
  .evt_done   (evt_done)
);

// File: tb/txdma_ctrl_tb.sv
module txdma_ctrl_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, run_en, poll_wr, desc_ack, desc_owned, rd_ack, tx_stat_vld, wb_ack;
  logic       desc_req, rd_req, wb_req, evt_stopped, evt_nobuf, evt_done;
  logic [2:0] state_code;

  txdma_ctrl u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .poll_wr(poll_wr),
    .desc_ack(desc_ack), .desc_owned(desc_owned), .rd_ack(rd_ack),
    .tx_stat_vld(tx_stat_vld), .wb_ack(wb_ack),
    .desc_req(desc_req), .rd_req(rd_req), .wb_req(wb_req),
    .state_code(state_code), .evt_stopped(evt_stopped),
    .evt_nobuf(evt_nobuf), .evt_done(evt_done)
  );

  // Expected-state codes, taken from R2
  localparam logic [2:0] ST = 3'b000, FE = 3'b001, RD = 3'b011,
                         WT = 3'b010, CL = 3'b111, SU = 3'b110;

  // Input field order: rst run poll dack owned rack stat wack
  localparam logic [7:0] I_RST  = 8'b1000_0000;
  localparam logic [7:0] I_RUN  = 8'b0100_0000;
  localparam logic [7:0] I_POLL = 8'b0010_0000;
  localparam logic [7:0] I_DACK = 8'b0001_0000;
  localparam logic [7:0] I_OWN  = 8'b0000_1000;
  localparam logic [7:0] I_RACK = 8'b0000_0100;
  localparam logic [7:0] I_STAT = 8'b0000_0010;
  localparam logic [7:0] I_WACK = 8'b0000_0001;

  // Observation: state, dreq, rreq, wreq, stopped, nobuf, done
  logic [8:0] exp_q[$];
  string      tag_q[$];
  int         n_run = 0;
  int         n_fail = 0;
  bit         done_flag = 0;

  function automatic logic [8:0] ob(input logic [2:0] s, input logic dq, input logic rq,
                                    input logic wq, input logic es, input logic en,
                                    input logic ed);
    return {s, dq, rq, wq, es, en, ed};
  endfunction

  task automatic step(input logic [7:0] in, input logic [8:0] e, input string tag);
    {rst, run_en, poll_wr, desc_ack, desc_owned, rd_ack, tx_stat_vld, wb_ack} = in;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        logic [8:0] a;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {state_code, desc_req, rd_req, wb_req, evt_stopped, evt_nobuf, evt_done};
        n_run++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    {rst, run_en, poll_wr, desc_ack, desc_owned, rd_ack, tx_stat_vld, wb_ack} = '0;
    @(negedge clk);
    // R1 reset state, run_en ignored under reset
    step(I_RST,         ob(ST,0,0,0,0,0,0), "R1 reset");
    step(I_RST | I_RUN, ob(ST,0,0,0,0,0,0), "R1 reset with run");
    step(8'h00,         ob(ST,0,0,0,0,0,0), "R1 idle stopped");
    // R6 poll while stopped has no effect
    step(I_POLL,        ob(ST,0,0,0,0,0,0), "R6 poll in stopped");
    // R3 start
    step(I_RUN,         ob(FE,1,0,0,0,0,0), "R3 start fetch");
    step(I_RUN,         ob(FE,0,0,0,0,0,0), "R3 desc_req one cycle");
    // R9 stray read ack during fetch
    step(I_RUN | I_RACK, ob(FE,0,0,0,0,0,0), "R9 stray rd_ack");
    // R4 normal frame
    step(I_RUN | I_DACK | I_OWN, ob(RD,0,1,0,0,0,0), "R4 owned to read");
    step(I_RUN | I_POLL, ob(RD,0,0,0,0,0,0), "R6 poll in read ignored");
    step(I_RUN | I_RACK, ob(WT,0,0,0,0,0,0), "R4 read to wait");
    step(I_RUN | I_STAT, ob(CL,0,0,1,0,0,0), "R4 wait to close");
    step(I_RUN | I_WACK, ob(FE,1,0,0,0,0,1), "R4 close to fetch done");
    // R5 unavailable descriptor
    step(I_RUN | I_DACK, ob(SU,0,0,0,0,1,0), "R5 enter suspend");
    step(I_RUN,          ob(SU,0,0,0,0,0,0), "R5 no repeat pulse");
    step(I_RUN | I_DACK | I_OWN, ob(SU,0,0,0,0,0,0), "R9 stray desc_ack in suspend");
    // R6 resume by poll
    step(I_RUN | I_POLL, ob(FE,1,0,0,0,0,0), "R6 poll resumes");
    step(I_RUN | I_DACK, ob(SU,0,0,0,0,1,0), "R5 suspend again");
    // R8 stop in suspend
    step(8'h00,          ob(ST,0,0,0,1,0,0), "R8 stop from suspend");
    step(8'h00,          ob(ST,0,0,0,0,0,0), "R8 stopped stays");
    // R7 stop mid-frame
    step(I_RUN,          ob(FE,1,0,0,0,0,0), "R3 restart");
    step(I_RUN | I_DACK | I_OWN, ob(RD,0,1,0,0,0,0), "R4 read again");
    step(I_RACK,         ob(WT,0,0,0,0,0,0), "R7 stop in read not cut");
    step(I_STAT,         ob(CL,0,0,1,0,0,0), "R7 close still issued");
    step(I_WACK,         ob(ST,0,0,0,1,0,1), "R7 stop after close");
    // R8 stop during outstanding fetch
    step(I_RUN,          ob(FE,1,0,0,0,0,0), "R3 restart 2");
    step(8'h00,          ob(FE,0,0,0,0,0,0), "R8 waits for desc_ack");
    step(I_DACK | I_OWN, ob(ST,0,0,0,1,0,0), "R8 stop at desc_ack owned");
    step(I_RUN,          ob(FE,1,0,0,0,0,0), "R3 restart 3");
    step(I_DACK,         ob(ST,0,0,0,1,0,0), "R8 stop at desc_ack unowned");
    // R1 reset mid-frame
    step(I_RUN,          ob(FE,1,0,0,0,0,0), "R3 restart 4");
    step(I_RUN | I_DACK | I_OWN, ob(RD,0,1,0,0,0,0), "R4 read 3");
    step(I_RST | I_RUN | I_RACK, ob(ST,0,0,0,0,0,0), "R1 reset mid-frame");
    step(I_RUN,          ob(FE,1,0,0,0,0,0), "R3 start after reset");
    step(8'h00,          ob(FE,0,0,0,0,0,0), "R9 fetch holds");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule